// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block runs a single-item vending machine with a fixed price of 75 cents. A coin receiver raises a coin-present line while it presents a two-bit coin code. The controller adds the coin's value into a credit register. It then compares the credit with the price and takes one of three actions:

- Below the price, it waits for the next coin.
- At the price, it fires a one-cycle release pulse. When the dispenser acknowledges, it clears the credit.
- Above the price, it pays change one nickel at a time. It fires a one-cycle eject pulse and waits for the changer's acknowledge. It then takes 5 cents off the credit and compares again, until the credit equals the price.

The three acknowledge-style inputs come from mechanical subsystems with no timing relation to the clock. Each one passes through its own flop chain at exactly one place before the controller looks at it. Every input level is acted on once. The controller does this by waiting for a line to rise in one state and for it to fall in the next. No state branches on more than one of these inputs. The credit register is brought out so that the datapath can be observed.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is held and directly after it, credit reads 0 and both eject_nickel and release_item are low.
- R2: Coin code 2'b00 adds 5, 2'b01 adds 10 and 2'b10 adds 25 to the credit. Code 2'b11 adds nothing. The code must be stable while coin_present is high.
- R3: A coin is added once per high period of coin_present, however long the line is held.
- R4: While the credit after a coin is below 75, no eject or release pulse is issued and the controller accepts the next coin.
- R5: When the credit equals 75, release_item pulses high for exactly one cycle. After drop_ready is seen, the credit is cleared to 0.
- R6: When the credit exceeds 75, eject_nickel pulses high for exactly one cycle per nickel owed. The number of pulses is (credit - 75) / 5. A release then follows.
- R7: Each acknowledge on change_ready takes exactly 5 off the credit, however long the line is held.
- R8: coin_present, change_ready and drop_ready each pass through SYNC_STAGES flops (default 2). A coin raised just after an edge changes credit at the third rising edge and not earlier.
- R9: The credit never exceeds 95.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coin_present | input | 1 | Coin receiver has a coin (asynchronous) |
| coin_code | input | 2 | Coin type: 00 nickel, 01 dime, 10 quarter, 11 worthless |
| change_ready | input | 1 | Changer acknowledge after a nickel is paid (asynchronous) |
| drop_ready | input | 1 | Dispenser acknowledge after an item falls (asynchronous) |
| eject_nickel | output | 1 | One-cycle command to pay one nickel |
| release_item | output | 1 | One-cycle command to drop one item |
| credit | output | 7 | Current accumulated credit in cents |

## Verification
Coin sequences that land exactly on the price show whether a release is issued without any change. Sequences that overshoot by 10 and by 20 cents tell a correct nickel count apart from an off-by-one in the change loop. A worthless code placed in the middle of an exact-price sequence shows whether that code is truly ignored. A coin held for many cycles and a changer acknowledge held for many cycles distinguish level-counted handshakes from edge-counted ones. A one-cycle-resolution look at credit after a coin is raised pins the synchronizer depth.

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter int CW          = 7,
  parameter int SYNC_STAGES = 2,
  parameter int PRICE       = 75,
  parameter int NICKEL      = 5,
  parameter int DIME        = 10,
  parameter int QUARTER     = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coin_present,
  input  logic [1:0]    coin_code,
  input  logic          change_ready,
  input  logic          drop_ready,
  output logic          eject_nickel,
  output logic          release_item,
  output logic [CW-1:0] credit
);

  localparam logic [CW-1:0] PRICE_V  = CW'(PRICE);
  localparam logic [CW-1:0] NICKEL_V = CW'(NICKEL);
  localparam logic [CW-1:0] MAX_V    = CW'(PRICE - NICKEL + QUARTER);

  typedef enum logic [2:0] {
    S_WAIT_COIN, S_WAIT_REL, S_EVAL, S_CHANGE, S_CHG_REL, S_DROP, S_DROP_REL
  } state_t;

  state_t state;
  logic [SYNC_STAGES-1:0] cp_q, chg_q, drp_q;
  logic cp_s, chg_s, drp_s;
  logic [CW-1:0] acc, coin_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cp_q  <= '0;
      chg_q <= '0;
      drp_q <= '0;
    end else begin
      cp_q  <= {cp_q[SYNC_STAGES-2:0], coin_present};
      chg_q <= {chg_q[SYNC_STAGES-2:0], change_ready};
      drp_q <= {drp_q[SYNC_STAGES-2:0], drop_ready};
    end

  assign cp_s  = cp_q[SYNC_STAGES-1];
  assign chg_s = chg_q[SYNC_STAGES-1];
  assign drp_s = drp_q[SYNC_STAGES-1];

  always_comb
    case (coin_code)
      2'b00:   coin_val = CW'(NICKEL);
      2'b01:   coin_val = CW'(DIME);
      2'b10:   coin_val = CW'(QUARTER);
      default: coin_val = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state        <= S_WAIT_COIN;
      acc          <= '0;
      eject_nickel <= 1'b0;
      release_item <= 1'b0;
    end else begin
      eject_nickel <= 1'b0;
      release_item <= 1'b0;
      case (state)
        S_WAIT_COIN:
          if (cp_s) begin
            acc   <= acc + coin_val;
            state <= S_WAIT_REL;
          end
        S_WAIT_REL:
          if (!cp_s) state <= S_EVAL;
        S_EVAL:
          if (acc > PRICE_V) begin
            eject_nickel <= 1'b1;
            state        <= S_CHANGE;
          end else if (acc == PRICE_V) begin
            release_item <= 1'b1;
            state        <= S_DROP;
          end else begin
            state <= S_WAIT_COIN;
          end
        S_CHANGE:
          if (chg_s) begin
            acc   <= acc - NICKEL_V;
            state <= S_CHG_REL;
          end
        S_CHG_REL:
          if (!chg_s) state <= S_EVAL;
        S_DROP:
          if (drp_s) begin
            acc   <= '0;
            state <= S_DROP_REL;
          end
        S_DROP_REL:
          if (!drp_s) state <= S_WAIT_COIN;
        default: state <= S_WAIT_COIN;
      endcase
    end

  assign credit = acc;

  a_r1_idle_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> acc == '0 && !eject_nickel && !release_item);
  a_r3_no_recount: assert property (@(posedge clk) disable iff (!rst_n) state == S_WAIT_REL |=> acc == $past(acc));
  a_r4_quiet_below: assert property (@(posedge clk) disable iff (!rst_n) (state == S_EVAL && acc < PRICE_V) |=> !eject_nickel && !release_item);
  a_r5_release_pulse: assert property (@(posedge clk) disable iff (!rst_n) release_item |=> !release_item);
  a_r5_release_at_price: assert property (@(posedge clk) disable iff (!rst_n) release_item |-> acc == PRICE_V);
  a_r6_eject_pulse: assert property (@(posedge clk) disable iff (!rst_n) eject_nickel |=> !eject_nickel);
  a_r6_eject_over_price: assert property (@(posedge clk) disable iff (!rst_n) eject_nickel |-> acc > PRICE_V);
  a_r7_one_nickel_off: assert property (@(posedge clk) disable iff (!rst_n) (state == S_CHANGE && chg_s) |=> acc == $past(acc) - NICKEL_V);
  a_r9_credit_bound: assert property (@(posedge clk) disable iff (!rst_n) acc <= MAX_V);

endmodule

// File: tb/vend_ctrl_bench.sv
module vend_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coin_present = 1'b0;
  logic [1:0] coin_code = 2'b00;
  logic change_ready = 1'b0;
  logic drop_ready = 1'b0;
  logic eject_nickel, release_item;
  logic [6:0] credit;

  int checks = 0, errors = 0;
  int nickels = 0, eject_cycles = 0, drops = 0;
  int ack_len = 4;
  bit done = 0;

  always #4 clk = ~clk;

  vend_ctrl u_vend_ctrl (
    .clk(clk), .rst_n(rst_n), .coin_present(coin_present), .coin_code(coin_code),
    .change_ready(change_ready), .drop_ready(drop_ready),
    .eject_nickel(eject_nickel), .release_item(release_item), .credit(credit)
  );

  localparam int NROW = 6;
  localparam logic [1:0] SEQ [NROW][8] = '{
    '{2, 2, 2, 0, 0, 0, 0, 0},
    '{1, 1, 1, 1, 1, 1, 1, 2},
    '{2, 2, 1, 1, 0, 0, 0, 0},
    '{2, 2, 1, 2, 0, 0, 0, 0},
    '{2, 1, 1, 1, 1, 0, 2, 0},
    '{2, 2, 3, 2, 0, 0, 0, 0}
  };
  localparam int CNT  [NROW] = '{3, 8, 5, 4, 7, 4};
  localparam int EXPN [NROW] = '{0, 4, 0, 2, 4, 0};

  function automatic int coin_value(input logic [1:0] c);
    case (c)
      2'b00: return 5;
      2'b01: return 10;
      2'b10: return 25;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic insert_coin(input logic [1:0] c, input int hold);
    @(negedge clk);
    coin_code = c;
    coin_present = 1'b1;
    repeat (hold) @(negedge clk);
    coin_present = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  always @(negedge clk) if (eject_nickel) eject_cycles++;

  initial begin
    forever begin
      @(negedge clk);
      if (eject_nickel) begin
        nickels++;
        repeat (3) @(negedge clk);
        change_ready = 1'b1;
        repeat (ack_len) @(negedge clk);
        change_ready = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (release_item) begin
        drops++;
        repeat (3) @(negedge clk);
        drop_ready = 1'b1;
        repeat (4) @(negedge clk);
        drop_ready = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0, e0, d0, sum;
    repeat (3) @(negedge clk);
    chk("R1 credit in reset", credit, 0);
    chk("R1 eject in reset", eject_nickel, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 credit after reset", credit, 0);
    chk("R1 release after reset", release_item, 0);

    // R8: synchronizer latency
    coin_code = 2'b01;
    coin_present = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 credit unchanged after two edges", credit, 0);
    @(negedge clk);
    chk("R8 credit at third edge", credit, 10);
    repeat (4) @(negedge clk);
    coin_present = 1'b0;
    repeat (6) @(negedge clk);
    // R3: long hold counted once
    insert_coin(2'b10, 40);
    chk("R3 held coin counted once", credit, 35);
    insert_coin(2'b11, 6);
    chk("R2 code 11 adds nothing", credit, 35);
    // bring to 80 with long changer acknowledge: R7
    ack_len = 25;
    n0 = nickels; d0 = drops;
    insert_coin(2'b10, 6);
    chk("R4 below price no release", drops - d0, 0);
    insert_coin(2'b01, 6);
    chk("R2 dime adds 10", credit, 70);
    insert_coin(2'b01, 6);
    repeat (150) @(negedge clk);
    chk("R7 one nickel for long ack", nickels - n0, 1);
    chk("R7 release after single decrement", drops - d0, 1);
    chk("R5 credit cleared", credit, 0);
    ack_len = 4;

    for (int r = 0; r < NROW; r++) begin
      n0 = nickels; e0 = eject_cycles; d0 = drops; sum = 0;
      for (int k = 0; k < CNT[r]; k++) begin
        insert_coin(SEQ[r][k], 6);
        sum += coin_value(SEQ[r][k]);
        if (sum < 75) begin
          chk("R2 running credit", credit, sum);
          chk("R4 no eject below price", nickels - n0, 0);
        end
      end
      repeat (200) @(negedge clk);
      chk("R6 nickels returned", nickels - n0, EXPN[r]);
      chk("R6 eject one cycle each", eject_cycles - e0, EXPN[r]);
      chk("R5 one release", drops - d0, 1);
      chk("R5 credit cleared after drop", credit, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule